// File: doc/BRIEF.md
# Thermal Event Domain Aggregator

This block collects the three threshold flags produced by each of a set of on-die temperature sensors. The flags are "above the upper threshold", "above the middle threshold" and "below the lower threshold". The block routes them through two levels of masking to three interrupt lines.

The first level works inside each voltage domain. A per-sensor mask picks which sensors feed that domain. The masked flags are OR-combined separately for each event type, and the result can be read as a domain status word. The second level works at the top. Each event type has its own enable bit per domain. Each type also has a sticky raw status bit per domain. The raw bit latches when the domain's combined event rises, and software may also set or clear it. Every enable and raw-status field is written through a pair of write-1 set/clear addresses.

The block also raises a warm-reset request with hysteresis. The request is based on the hottest valid sensor reading and uses separate assert and release thresholds. Software drives everything through a simple word-addressed write strobe with a combinational read port.

Top module: `thermal_evt_agg`

## Requirements
- R1: Each active domain d has a sensor mask written at address d (set) and address 4+d (clear). Only 1 bits in the write data take effect, and 0 bits change nothing. A read of either address returns the current mask.
- R2: Reading address 8+d returns domain d's combined status. Bit 0 is the OR of the masked above-upper flags, bit 1 is the OR of the masked above-middle flags, and bit 2 is the OR of the masked below-lower flags. Unmasked sensors do not contribute.
- R3: Only domains 0 and 1 exist. Writes to the mask addresses of domains 2 and 3 are ignored, and every mask and status read for those domains returns 0.
- R4: Event type t (0 above-upper, 1 above-middle, 2 below-lower) has a per-domain enable field. Bit d of the field belongs to domain d. The field is set through address 12+t and cleared through address 15+t, with write-1 semantics, and a read of either address returns the field. Bits for domains 2 and above are ignored.
- R5: A domain's raw status bit for type t becomes 1 one clock after that domain's combined event for type t rises. The bit stays 1 after the event goes away.
- R6: Writing 1s to address 18+t sets raw status bits of type t. Writing 1s to address 21+t clears them. If the event is still active when a bit is cleared, the bit returns to 1 one cycle after the clear. A read of either address returns the raw field.
- R7: Each interrupt output is high exactly when some domain has both its raw status bit and its enable bit set for that event type.
- R8: Address 24 holds the assert threshold in bits 9:0 and the release threshold in bits 25:16. The warm-reset request rises one clock after the hottest valid reading becomes strictly greater than the assert threshold.
- R9: Once raised, the warm-reset request stays high until the hottest valid reading is strictly below the release threshold. It then falls one clock later.
- R10: Readings whose valid bit is low take no part in the hottest-reading comparison.
- R11: After reset, all masks, enables and raw bits are 0, the assert threshold is 0x3FF, the release threshold is 0, and all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| sens_hot2 | input | NUM_SENS | Per-sensor above-upper-threshold flags |
| sens_hot1 | input | NUM_SENS | Per-sensor above-middle-threshold flags |
| sens_cold0 | input | NUM_SENS | Per-sensor below-lower-threshold flags |
| sens_temp | input | NUM_SENS*TW | Packed sensor readings, sensor i in bits [i*TW +: TW] |
| sens_valid | input | NUM_SENS | Reading valid per sensor |
| irq_hot2 | output | 1 | Above-upper interrupt |
| irq_hot1 | output | 1 | Above-middle interrupt |
| irq_cold0 | output | 1 | Below-lower interrupt |
| warm_rst_req | output | 1 | Warm-reset request with hysteresis |

## Verification
The checker watches several rules on every cycle. The warm-reset request never rises unless the hottest reading exceeded the assert threshold, and never falls unless that reading was below the release threshold. A raw bit only drops when a clear write covers it, and every bit named in a clear write is 0 on the next cycle. A mask set write always leaves its bits set, and an interrupt stays low while its enable field is zero. The directed scenarios cover the rest. They show which sensors a mask selects, that the unused domain slots stay silent, the exact cycle in which a raw bit re-latches after a clear under a live event, and the behaviour at the equal-to-threshold boundaries.

// File: rtl/thermal_agg_pkg.sv
// Package: constants shared by the thermal event aggregator and its checker.
// Assumes a 4-slot domain address space and three event types.
package thermal_agg_pkg;
    localparam int NUM_EVT   = 3;
    localparam int DOM_SLOTS = 4;
    localparam int ADDR_W    = 5;
    localparam int DATA_W    = 32;

    // Event type indices (also status bit positions)
    localparam int EVT_HOT2  = 0;
    localparam int EVT_HOT1  = 1;
    localparam int EVT_COLD0 = 2;

    // Word address bases
    localparam logic [ADDR_W-1:0] A_MASK_SET = 5'd0;
    localparam logic [ADDR_W-1:0] A_MASK_CLR = 5'd4;
    localparam logic [ADDR_W-1:0] A_DSTAT    = 5'd8;
    localparam logic [ADDR_W-1:0] A_EN_SET   = 5'd12;
    localparam logic [ADDR_W-1:0] A_EN_CLR   = 5'd15;
    localparam logic [ADDR_W-1:0] A_RAW_SET  = 5'd18;
    localparam logic [ADDR_W-1:0] A_RAW_CLR  = 5'd21;
    localparam logic [ADDR_W-1:0] A_WRST_CFG = 5'd24;

    // Bit offset of the release threshold in the warm-reset word
    localparam int REL_LSB = 16;
endpackage

// File: rtl/thermal_dom_combine.sv
// Module: thermal_dom_combine
// Combines the masked sensor flags of one voltage domain into one bit per
// event type. Purely combinational; assumes flags are already synchronous.
module thermal_dom_combine
    import thermal_agg_pkg::*;
#(
    parameter int NUM_SENS = 4
) (
    input  logic [NUM_EVT-1:0][NUM_SENS-1:0] flags,
    input  logic [NUM_SENS-1:0]              mask,
    output logic [NUM_EVT-1:0]               evt
);
    genvar t;
    generate
        for (t = 0; t < NUM_EVT; t++) begin : g_type
            // OR of the masked flags for this event type
            assign evt[t] = |(flags[t] & mask);
        end
    endgenerate
endmodule

// File: rtl/thermal_irq_stat.sv
// Module: thermal_irq_stat
// Raw status and interrupt for one event type across all active domains.
// A raw bit latches on the rising edge of its domain event, or again one
// cycle after a clear if the event is still present. Assumes set and clear
// are never requested in the same cycle (they come from different addresses).
module thermal_irq_stat #(
    parameter int NUM_DOM = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_DOM-1:0] evt,
    input  logic [NUM_DOM-1:0] sw_set,
    input  logic [NUM_DOM-1:0] sw_clr,
    input  logic [NUM_DOM-1:0] en,
    output logic [NUM_DOM-1:0] raw,
    output logic               irq
);
    logic [NUM_DOM-1:0] evt_q;
    logic [NUM_DOM-1:0] clr_q;
    logic [NUM_DOM-1:0] hw_set;

    // Hardware latch request: a fresh edge, or an event that outlived a clear
    assign hw_set = evt & (~evt_q | clr_q);

    // Sticky raw status with clear priority, plus edge-detect history
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            evt_q <= '0;
            clr_q <= '0;
            raw   <= '0;
        end else begin
            evt_q <= evt;
            clr_q <= sw_clr;
            raw   <= (raw | sw_set | hw_set) & ~sw_clr;
        end
    end

    // Interrupt when any enabled domain has raw status pending
    assign irq = |(raw & en);
endmodule

// File: rtl/thermal_wrst_hyst.sv
// Module: thermal_wrst_hyst
// Finds the hottest valid reading and drives a warm-reset request that sets
// above thr_hi and releases below thr_lo. Assumes thr_lo <= thr_hi.
module thermal_wrst_hyst #(
    parameter int NUM_SENS = 4,
    parameter int TW       = 10
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NUM_SENS*TW-1:0] temp,
    input  logic [NUM_SENS-1:0]    valid,
    input  logic [TW-1:0]          thr_hi,
    input  logic [TW-1:0]          thr_lo,
    output logic [TW-1:0]          tmax,
    output logic                   req
);
    // Maximum over the valid readings (0 when none are valid)
    always_comb begin
        tmax = '0;
        for (int i = 0; i < NUM_SENS; i++) begin
            if (valid[i] && (temp[i*TW +: TW] > tmax)) begin
                tmax = temp[i*TW +: TW];
            end
        end
    end

    // Hysteresis state: assert above thr_hi, release below thr_lo
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req <= 1'b0;
        end else if (!req && (tmax > thr_hi)) begin
            req <= 1'b1;
        end else if (req && (tmax < thr_lo)) begin
            req <= 1'b0;
        end
    end
endmodule

// File: rtl/thermal_evt_agg.sv
// Module: thermal_evt_agg (top)
// Two-level masking of sensor threshold flags (per sensor within each domain,
// then per domain per event type) into three interrupts, plus a hysteretic
// warm-reset request. Register access: single-cycle write strobe, reads are
// combinational. Assumes 2 <= ACT_DOM <= 4, NUM_SENS <= 32, TW <= 16.
module thermal_evt_agg
    import thermal_agg_pkg::*;
#(
    parameter int NUM_SENS = 4,
    parameter int ACT_DOM  = 2,
    parameter int TW       = 10
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   reg_wr,
    input  logic [ADDR_W-1:0]      reg_addr,
    input  logic [DATA_W-1:0]      reg_wdata,
    output logic [DATA_W-1:0]      reg_rdata,
    input  logic [NUM_SENS-1:0]    sens_hot2,
    input  logic [NUM_SENS-1:0]    sens_hot1,
    input  logic [NUM_SENS-1:0]    sens_cold0,
    input  logic [NUM_SENS*TW-1:0] sens_temp,
    input  logic [NUM_SENS-1:0]    sens_valid,
    output logic                   irq_hot2,
    output logic                   irq_hot1,
    output logic                   irq_cold0,
    output logic                   warm_rst_req
);
    localparam logic [TW-1:0] THR_HI_RST = {TW{1'b1}};

    logic [NUM_EVT-1:0][NUM_SENS-1:0] flags_all;
    logic [ACT_DOM-1:0][NUM_SENS-1:0] mask_q;
    logic [NUM_EVT-1:0][ACT_DOM-1:0]  en_q;
    logic [TW-1:0]                    thr_hi_q;
    logic [TW-1:0]                    thr_lo_q;
    logic [ACT_DOM-1:0]               mask_set_hit;
    logic [ACT_DOM-1:0]               mask_clr_hit;
    logic [NUM_EVT-1:0]               en_set_hit;
    logic [NUM_EVT-1:0]               en_clr_hit;
    logic [ACT_DOM-1:0][NUM_EVT-1:0]  dom_evt;
    logic [NUM_EVT-1:0][ACT_DOM-1:0]  evt_by_type;
    logic [NUM_EVT-1:0][ACT_DOM-1:0]  sw_set;
    logic [NUM_EVT-1:0][ACT_DOM-1:0]  sw_clr;
    logic [NUM_EVT-1:0][ACT_DOM-1:0]  raw_w;
    logic [NUM_EVT-1:0]               irq_w;
    logic [NUM_SENS-1:0]              mask_rd  [DOM_SLOTS];
    logic [NUM_EVT-1:0]               dstat_rd [DOM_SLOTS];
    logic [TW-1:0]                    tmax_w;
    logic                             wrst_cfg_hit;
    logic                             unused_wdata;

    assign flags_all    = {sens_cold0, sens_hot1, sens_hot2};
    assign wrst_cfg_hit = reg_wr && (reg_addr == A_WRST_CFG);
    assign unused_wdata = ^reg_wdata;

    genvar d, t;
    generate
        for (d = 0; d < ACT_DOM; d++) begin : g_dom
            // Address decode for this domain's mask pair
            assign mask_set_hit[d] = reg_wr && (reg_addr == A_MASK_SET + ADDR_W'(d));
            assign mask_clr_hit[d] = reg_wr && (reg_addr == A_MASK_CLR + ADDR_W'(d));

            // Mask register with write-1 set/clear
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    mask_q[d] <= '0;
                end else if (mask_set_hit[d]) begin
                    mask_q[d] <= mask_q[d] | reg_wdata[NUM_SENS-1:0];
                end else if (mask_clr_hit[d]) begin
                    mask_q[d] <= mask_q[d] & ~reg_wdata[NUM_SENS-1:0];
                end
            end

            thermal_dom_combine #(.NUM_SENS(NUM_SENS)) comb_i (
                .flags (flags_all),
                .mask  (mask_q[d]),
                .evt   (dom_evt[d])
            );
        end

        for (d = 0; d < DOM_SLOTS; d++) begin : g_slot
            // Read views padded with zeros for unused domain slots
            if (d < ACT_DOM) begin : g_act
                assign mask_rd[d]  = mask_q[d];
                assign dstat_rd[d] = dom_evt[d];
            end else begin : g_idle
                assign mask_rd[d]  = '0;
                assign dstat_rd[d] = '0;
            end
        end

        for (t = 0; t < NUM_EVT; t++) begin : g_type
            assign en_set_hit[t] = reg_wr && (reg_addr == A_EN_SET + ADDR_W'(t));
            assign en_clr_hit[t] = reg_wr && (reg_addr == A_EN_CLR + ADDR_W'(t));
            assign sw_set[t] = (reg_wr && (reg_addr == A_RAW_SET + ADDR_W'(t)))
                               ? reg_wdata[ACT_DOM-1:0] : '0;
            assign sw_clr[t] = (reg_wr && (reg_addr == A_RAW_CLR + ADDR_W'(t)))
                               ? reg_wdata[ACT_DOM-1:0] : '0;

            for (d = 0; d < ACT_DOM; d++) begin : g_tr
                assign evt_by_type[t][d] = dom_evt[d][t];
            end

            // Per-type domain enable with write-1 set/clear
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    en_q[t] <= '0;
                end else if (en_set_hit[t]) begin
                    en_q[t] <= en_q[t] | reg_wdata[ACT_DOM-1:0];
                end else if (en_clr_hit[t]) begin
                    en_q[t] <= en_q[t] & ~reg_wdata[ACT_DOM-1:0];
                end
            end

            thermal_irq_stat #(.NUM_DOM(ACT_DOM)) stat_i (
                .clk    (clk),
                .rst_n  (rst_n),
                .evt    (evt_by_type[t]),
                .sw_set (sw_set[t]),
                .sw_clr (sw_clr[t]),
                .en     (en_q[t]),
                .raw    (raw_w[t]),
                .irq    (irq_w[t])
            );
        end
    endgenerate

    assign irq_hot2  = irq_w[EVT_HOT2];
    assign irq_hot1  = irq_w[EVT_HOT1];
    assign irq_cold0 = irq_w[EVT_COLD0];

    // Warm-reset threshold word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            thr_hi_q <= THR_HI_RST;
            thr_lo_q <= '0;
        end else if (wrst_cfg_hit) begin
            thr_hi_q <= reg_wdata[TW-1:0];
            thr_lo_q <= reg_wdata[REL_LSB +: TW];
        end
    end

    thermal_wrst_hyst #(.NUM_SENS(NUM_SENS), .TW(TW)) wrst_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .temp   (sens_temp),
        .valid  (sens_valid),
        .thr_hi (thr_hi_q),
        .thr_lo (thr_lo_q),
        .tmax   (tmax_w),
        .req    (warm_rst_req)
    );

    // Combinational read multiplexer
    always_comb begin
        reg_rdata = '0;
        for (int i = 0; i < DOM_SLOTS; i++) begin
            if (reg_addr == A_MASK_SET + ADDR_W'(i) || reg_addr == A_MASK_CLR + ADDR_W'(i)) begin
                reg_rdata = DATA_W'(mask_rd[i]);
            end
            if (reg_addr == A_DSTAT + ADDR_W'(i)) begin
                reg_rdata = DATA_W'(dstat_rd[i]);
            end
        end
        for (int i = 0; i < NUM_EVT; i++) begin
            if (reg_addr == A_EN_SET + ADDR_W'(i) || reg_addr == A_EN_CLR + ADDR_W'(i)) begin
                reg_rdata = DATA_W'(en_q[i]);
            end
            if (reg_addr == A_RAW_SET + ADDR_W'(i) || reg_addr == A_RAW_CLR + ADDR_W'(i)) begin
                reg_rdata = DATA_W'(raw_w[i]);
            end
        end
        if (reg_addr == A_WRST_CFG) begin
            reg_rdata[TW-1:0]         = thr_hi_q;
            reg_rdata[REL_LSB +: TW]  = thr_lo_q;
        end
    end
endmodule

// File: rtl/thermal_evt_agg_chk.sv
// Module: thermal_evt_agg_chk
// Cycle-by-cycle properties for thermal_evt_agg, attached through bind.
module thermal_evt_agg_chk
    import thermal_agg_pkg::*;
#(
    parameter int NUM_SENS = 4,
    parameter int ACT_DOM  = 2,
    parameter int TW       = 10
) (
    input logic                             clk,
    input logic                             rst_n,
    input logic                             warm_rst_req,
    input logic [TW-1:0]                    tmax,
    input logic [TW-1:0]                    thr_hi,
    input logic [TW-1:0]                    thr_lo,
    input logic [NUM_EVT-1:0][ACT_DOM-1:0]  raw,
    input logic [NUM_EVT-1:0][ACT_DOM-1:0]  en,
    input logic [NUM_EVT-1:0][ACT_DOM-1:0]  sw_clr,
    input logic [NUM_EVT-1:0]               irq,
    input logic [ACT_DOM-1:0][NUM_SENS-1:0] mask,
    input logic [ACT_DOM-1:0]               mask_set_hit,
    input logic [NUM_SENS-1:0]              wdata
);
    // R8: request only rises after the hottest reading exceeded the assert level
    a_r8_rise_needs_hot: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(warm_rst_req) |-> $past(tmax > thr_hi));

    // R9: request only falls after the hottest reading dropped below release level
    a_r9_fall_needs_cool: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(warm_rst_req) |-> $past(tmax < thr_lo));

    // R9: request holds while the reading is not below the release level
    a_r9_hold_band: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_rst_req && (tmax >= thr_lo)) |=> warm_rst_req);

    genvar t, d;
    generate
        for (t = 0; t < NUM_EVT; t++) begin : g_t
            // R5: a raw bit not covered by a clear stays set
            a_r5_raw_sticky: assert property (@(posedge clk) disable iff (!rst_n)
                ((raw[t] & ~sw_clr[t]) != '0) |=>
                ((($past(raw[t]) & ~$past(sw_clr[t])) & ~raw[t]) == '0));

            // R6: every bit named in a clear write is 0 on the next cycle
            a_r6_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
                (sw_clr[t] != '0) |=> ((raw[t] & $past(sw_clr[t])) == '0));

            // R7: no interrupt while the type's enable field is empty
            a_r7_irq_quiet: assert property (@(posedge clk) disable iff (!rst_n)
                (en[t] == '0) |-> !irq[t]);
        end
        for (d = 0; d < ACT_DOM; d++) begin : g_d
            // R1: a set write leaves all written mask bits set
            a_r1_mask_set: assert property (@(posedge clk) disable iff (!rst_n)
                mask_set_hit[d] |=> ((mask[d] & $past(wdata)) == $past(wdata)));
        end
    endgenerate
endmodule

bind thermal_evt_agg thermal_evt_agg_chk #(
    .NUM_SENS (NUM_SENS),
    .ACT_DOM  (ACT_DOM),
    .TW       (TW)
) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .warm_rst_req (warm_rst_req),
    .tmax         (tmax_w),
    .thr_hi       (thr_hi_q),
    .thr_lo       (thr_lo_q),
    .raw          (raw_w),
    .en           (en_q),
    .sw_clr       (sw_clr),
    .irq          ({irq_cold0, irq_hot1, irq_hot2}),
    .mask         (mask_q),
    .mask_set_hit (mask_set_hit),
    .wdata        (reg_wdata[NUM_SENS-1:0])
);

// File: tb/thermal_evt_agg_tb.sv
// Directed bench for thermal_evt_agg: one task per scenario.
module thermal_evt_agg_tb_top;
    localparam int NS = 4;
    localparam int TW = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr = 1'b0;
    logic [4:0]    reg_addr = '0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic [NS-1:0] hot2 = '0, hot1 = '0, cold0 = '0, valid = '0;
    logic [NS*TW-1:0] temp = '0;
    logic          irq_hot2, irq_hot1, irq_cold0, wrst;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk; // 50 MHz

    thermal_evt_agg #(.NUM_SENS(NS), .ACT_DOM(2), .TW(TW)) dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .sens_hot2(hot2), .sens_hot1(hot1), .sens_cold0(cold0),
        .sens_temp(temp), .sens_valid(valid),
        .irq_hot2(irq_hot2), .irq_hot1(irq_hot1), .irq_cold0(irq_cold0),
        .warm_rst_req(wrst)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] v);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] v);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    task automatic set_temp(input int i, input int v);
        temp[i*TW +: TW] = TW'(v);
    endtask

    task automatic t_reset;
        logic [31:0] v;
        rd(5'd0, v);  chk("R11 mask0", v, 0);
        rd(5'd12, v); chk("R11 en hot2", v, 0);
        rd(5'd18, v); chk("R11 raw hot2", v, 0);
        rd(5'd24, v); chk("R11 wrst cfg", v, 32'h3FF);
        chk("R11 outputs", {irq_hot2, irq_hot1, irq_cold0, wrst}, 0);
    endtask

    task automatic t_mask;
        logic [31:0] v;
        wr(5'd0, 32'h5);
        rd(5'd0, v); chk("R1 set read", v, 5);
        rd(5'd4, v); chk("R1 clr read", v, 5);
        wr(5'd4, 32'h1);
        rd(5'd0, v); chk("R1 after clear", v, 4);
        wr(5'd0, 32'h0);
        rd(5'd4, v); chk("R1 zero write no effect", v, 4);
        wr(5'd1, 32'h3);
        rd(5'd1, v); chk("R1 dom1 mask", v, 3);
    endtask

    task automatic t_unused;
        logic [31:0] v;
        wr(5'd2, 32'hF);
        wr(5'd3, 32'hF);
        rd(5'd2, v);  chk("R3 dom2 mask", v, 0);
        rd(5'd7, v);  chk("R3 dom3 mask", v, 0);
        @(negedge clk);
        hot2 = 4'hF; hot1 = 4'hF; cold0 = 4'hF;
        rd(5'd10, v); chk("R3 dom2 status", v, 0);
        rd(5'd11, v); chk("R3 dom3 status", v, 0);
        @(negedge clk);
        hot2 = '0; hot1 = '0; cold0 = '0;
    endtask

    task automatic t_dstat;
        logic [31:0] v;
        @(negedge clk);
        hot2 = 4'b0100;
        rd(5'd8, v); chk("R2 dom0 hot2", v, 1);
        rd(5'd9, v); chk("R2 dom1 masked out", v, 0);
        cold0 = 4'b0010;
        rd(5'd9, v); chk("R2 dom1 cold0", v, 4);
        hot1 = 4'b1000;
        rd(5'd8, v); chk("R2 dom0 unmasked hot1", v, 1);
        rd(5'd9, v); chk("R2 dom1 unmasked hot1", v, 4);
        @(negedge clk);
        hot2 = '0; hot1 = '0; cold0 = '0;
        for (int t = 0; t < 3; t++) wr(5'(21 + t), 32'h3);
    endtask

    task automatic t_enable;
        logic [31:0] v;
        wr(5'd12, 32'h3);
        wr(5'd15, 32'h1);
        rd(5'd12, v); chk("R4 set/clr", v, 2);
        wr(5'd13, 32'hF);
        rd(5'd16, v); chk("R4 upper bits ignored", v, 3);
        wr(5'd16, 32'h3);
        rd(5'd13, v); chk("R4 clear all", v, 0);
    endtask

    task automatic t_raw_edge;
        logic [31:0] v;
        rd(5'd18, v); chk("R5 raw clean", v, 0);
        @(negedge clk);
        hot2 = 4'b0001;
        @(negedge clk);
        chk("R7 irq after edge", irq_hot2, 1);
        rd(5'd18, v); chk("R5 raw latched dom1", v, 2);
        hot2 = '0;
        @(negedge clk);
        rd(5'd21, v); chk("R5 raw sticky", v, 2);
        chk("R7 irq sticky", irq_hot2, 1);
    endtask

    task automatic t_raw_clear;
        logic [31:0] v;
        wr(5'd21, 32'h2);
        #1;
        chk("R6 cleared", irq_hot2, 0);
        @(negedge clk);
        hot2 = 4'b0001;
        @(negedge clk);
        chk("R5 relatch on new edge", irq_hot2, 1);
        wr(5'd21, 32'h2);
        #1;
        chk("R6 clear under live event", irq_hot2, 0);
        @(negedge clk);
        chk("R6 relatch next cycle", irq_hot2, 1);
        hot2 = '0;
        wr(5'd19, 32'h1);
        rd(5'd19, v); chk("R6 software set", v, 1);
        chk("R7 no enable no irq", irq_hot1, 0);
        wr(5'd13, 32'h1);
        #1;
        chk("R7 enable drives irq", irq_hot1, 1);
    endtask

    task automatic t_wrst;
        logic [31:0] v;
        wr(5'd24, (32'd500 << 16) | 32'd600);
        rd(5'd24, v); chk("R8 cfg readback", v, (32'd500 << 16) | 32'd600);
        @(negedge clk);
        set_temp(0, 550); valid = 4'b0001;
        set_temp(1, 700);
        @(negedge clk);
        chk("R10 invalid reading ignored", wrst, 0);
        valid = 4'b0011;
        @(negedge clk);
        chk("R8 asserted", wrst, 1);
        set_temp(1, 600);
        @(negedge clk);
        chk("R9 hold in band", wrst, 1);
        set_temp(1, 500); set_temp(0, 450);
        @(negedge clk);
        chk("R9 hold at release level", wrst, 1);
        set_temp(1, 499);
        @(negedge clk);
        chk("R9 released", wrst, 0);
        set_temp(1, 600);
        @(negedge clk);
        chk("R8 equal not above", wrst, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_mask();
        t_unused();
        t_dstat();
        t_enable();
        wr(5'd12, 32'h2);
        t_raw_edge();
        t_raw_clear();
        t_wrst();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule